// File: doc/BRIEF.md
# Branch Target Buffer

This block is a small, fully associative table of recently taken branches. It is consulted by the fetch stage in the same cycle in which the instruction memory is read. The fetch stage presents its current PC on the lookup port. All entries compare their stored branch address against the full PC at once. A matching entry supplies its stored target and its prediction bit, and the block returns the PC to fetch next. Without a taken hit, that PC is the sequential address PC+4.

A later pipeline stage reports each resolved branch on the resolve port. It gives the branch PC, whether the branch was taken, the real target, and whether the branch hit at fetch time.

- **Taken branches:** a taken branch that is absent is written into a free entry. When no entry is free, it replaces the entry under a round-robin pointer. A taken branch that is already stored has its target rewritten in place.
- **Not-taken hits:** a branch that hit but resolved not taken removes its entry. The block flags a mispredict in the same cycle.

The block does not flush or kill instructions. It only raises the mispredict flag.

Each entry is a two-state machine:

- **EMPTY → HELD** on *load*. A load allocates or replaces the entry.
- **HELD → HELD** on *load*. This rewrites the tag and the target.
- **HELD → EMPTY** on *drop*. This is the not-taken delete.

Each resolve cycle is classified as one of the following actions:

- IDLE: no resolve is presented.
- ALLOC: taken and absent.
- RETARGET: taken and present.
- DELETE: not taken, hit at fetch, and still present.
- IGNORE: any other valid resolve.

Top module: `btb_unit`

## Requirements
- R1: After reset every entry is empty: no lookup hits, `lk_taken` is 0, and `lk_next_pc` is `lk_pc`+4 modulo 2^32.
- R2: A lookup hits only when a held entry stores exactly the full 32-bit `lk_pc`. A PC that differs in any bit, including bit 31 or PC+4, misses.
- R3: On a hit, `lk_taken` equals the entry's prediction bit, which is set to 1 when the entry is written. `lk_next_pc` is then the stored target. On a miss, `lk_taken` is 0 and `lk_next_pc` is `lk_pc`+4 with wrap-around.
- R4: A valid taken resolve whose PC is absent writes PC and target into an entry, visible from the next cycle. The entry is the lowest-numbered empty one if any entry is empty.
- R5: A valid taken resolve whose PC is present rewrites that entry's target. It allocates no entry and does not move the replacement pointer.
- R6: A valid not-taken resolve with `rs_was_hit`=1 removes the matching entry, if present, from the next cycle on.
- R7: `rs_mispredict` is 1 exactly in a cycle with `rs_valid`=1, `rs_was_hit`=1 and `rs_taken`=0. A not-taken resolve with `rs_was_hit`=0 changes no entry.
- R8: The replacement pointer resets to entry 0 and advances by one, modulo 8, on every allocation, including allocations into empty entries. An allocation with no empty entry overwrites the entry under the pointer.
- R9: A lookup and a resolve in the same cycle, even of the same PC, are both answered from the contents before that cycle's update.
- R10: With `rs_valid`=0 the table contents do not change, whatever the other resolve inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | 32 | Fetch PC probed this cycle |
| lk_hit | output | 1 | A held entry matches `lk_pc` |
| lk_taken | output | 1 | Hit with prediction bit set |
| lk_next_pc | output | 32 | Predicted next fetch PC |
| rs_valid | input | 1 | A resolved branch is presented |
| rs_pc | input | 32 | Address of the resolved branch |
| rs_taken | input | 1 | Resolved outcome, 1 = taken |
| rs_target | input | 32 | Real target of the branch |
| rs_was_hit | input | 1 | The branch hit at fetch time |
| rs_mispredict | output | 1 | Hit branch resolved not taken |

## Verification
The assertions assume that the table never holds two entries with the same PC. They also assume that `rs_was_hit` is only a hint: a delete happens only when the resolve PC is actually found. The bench keeps within these assumptions by driving every write through the resolve port, so duplicates can only arise from a design fault. Its pseudo-random phase draws PCs from a pool of twelve addresses against eight entries. This forces allocation into empty slots, overwrites, retargets and deletes, and sets `rs_was_hit` independently of the real contents.

// File: rtl/btb_pkg.sv
package btb_pkg;

    // Life cycle of one buffer slot
    typedef enum logic [0:0] {
        SLOT_EMPTY = 1'b0,
        SLOT_HELD  = 1'b1
    } slot_state_e;

    // What a resolve cycle does to the table
    typedef enum logic [2:0] {
        RES_IDLE,
        RES_ALLOC,
        RES_RETARGET,
        RES_DELETE,
        RES_IGNORE
    } res_action_e;

endpackage

// File: rtl/btb_match.sv
module btb_match #(
    parameter int N     = 8,
    parameter int PC_W  = 32,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [PC_W-1:0]         key,
    input  logic [N-1:0][PC_W-1:0]  tags,
    input  logic [N-1:0]            held,
    output logic [N-1:0]            hit_vec,
    output logic                    hit,
    output logic [IDX_W-1:0]        hit_idx
);

    // one comparator per slot
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = held[g] && (tags[g] == key);
    end

    assign hit = |hit_vec;

    // lowest matching slot wins; at most one matches in practice
    always_comb begin
        hit_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                hit_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/btb_slot.sv
module btb_slot
    import btb_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            drop,
    input  logic [PC_W-1:0] load_tag,
    input  logic [PC_W-1:0] load_tgt,
    output logic            held,
    output logic [PC_W-1:0] tag,
    output logic [PC_W-1:0] tgt,
    output logic            pred
);

    slot_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLOT_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY: if (load) state_d = SLOT_HELD;
            SLOT_HELD:  if (drop) state_d = SLOT_EMPTY;
            default:    state_d = SLOT_EMPTY;
        endcase
    end

    // payload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag  <= '0;
            tgt  <= '0;
            pred <= 1'b0;
        end else if (load) begin
            tag  <= load_tag;
            tgt  <= load_tgt;
            pred <= 1'b1;
        end else if (drop) begin
            pred <= 1'b0;
        end
    end

    assign held = (state_q == SLOT_HELD);

endmodule

// File: rtl/btb_victim.sv
module btb_victim #(
    parameter int N      = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     held,
    input  logic             alloc,
    output logic [IDX_W-1:0] victim_idx,
    output logic [IDX_W-1:0] rr_ptr
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

    logic [IDX_W-1:0] free_idx;
    logic             any_free;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_ptr <= '0;
        end else if (alloc) begin
            rr_ptr <= (rr_ptr == LAST) ? '0 : rr_ptr + 1'b1;
        end
    end

    assign any_free = ~&held;

    always_comb begin
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!held[i]) begin
                free_idx = IDX_W'(i);
            end
        end
    end

    assign victim_idx = any_free ? free_idx : rr_ptr;

endmodule

// File: rtl/btb_unit.sv
module btb_unit
    import btb_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    parameter int PC_W        = 32,
    parameter int PC_STEP     = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_hit,
    output logic            lk_taken,
    output logic [PC_W-1:0] lk_next_pc,
    input  logic            rs_valid,
    input  logic [PC_W-1:0] rs_pc,
    input  logic            rs_taken,
    input  logic [PC_W-1:0] rs_target,
    input  logic            rs_was_hit,
    output logic            rs_mispredict
);

    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
    localparam logic [PC_W-1:0] STEP_V = PC_W'(PC_STEP);

    logic [NUM_ENTRIES-1:0][PC_W-1:0] tag_arr;
    logic [NUM_ENTRIES-1:0][PC_W-1:0] tgt_arr;
    logic [NUM_ENTRIES-1:0]           pred_vec;
    logic [NUM_ENTRIES-1:0]           held_vec;
    logic [NUM_ENTRIES-1:0]           load_vec;
    logic [NUM_ENTRIES-1:0]           drop_vec;
    logic [NUM_ENTRIES-1:0]           lk_hit_vec;
    logic [NUM_ENTRIES-1:0]           rs_hit_vec;
    logic [IDX_W-1:0]                 lk_idx;
    logic [IDX_W-1:0]                 rs_idx;
    logic [IDX_W-1:0]                 victim_idx;
    logic [IDX_W-1:0]                 rr_ptr;
    logic                             rs_hit;
    logic                             alloc_fire;
    res_action_e                      action;

    // lookup side
    btb_match #(.N(NUM_ENTRIES), .PC_W(PC_W)) lk_match_i (
        .key     (lk_pc),
        .tags    (tag_arr),
        .held    (held_vec),
        .hit_vec (lk_hit_vec),
        .hit     (lk_hit),
        .hit_idx (lk_idx)
    );

    // resolve side
    btb_match #(.N(NUM_ENTRIES), .PC_W(PC_W)) rs_match_i (
        .key     (rs_pc),
        .tags    (tag_arr),
        .held    (held_vec),
        .hit_vec (rs_hit_vec),
        .hit     (rs_hit),
        .hit_idx (rs_idx)
    );

    btb_victim #(.N(NUM_ENTRIES)) victim_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .held       (held_vec),
        .alloc      (alloc_fire),
        .victim_idx (victim_idx),
        .rr_ptr     (rr_ptr)
    );

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
        btb_slot #(.PC_W(PC_W)) slot_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (load_vec[g]),
            .drop     (drop_vec[g]),
            .load_tag (rs_pc),
            .load_tgt (rs_target),
            .held     (held_vec[g]),
            .tag      (tag_arr[g]),
            .tgt      (tgt_arr[g]),
            .pred     (pred_vec[g])
        );
    end

    // classify the resolve cycle
    always_comb begin
        action = RES_IDLE;
        if (rs_valid) begin
            if (rs_taken) begin
                action = rs_hit ? RES_RETARGET : RES_ALLOC;
            end else if (rs_was_hit && rs_hit) begin
                action = RES_DELETE;
            end else begin
                action = RES_IGNORE;
            end
        end
    end

    // per-slot commands
    always_comb begin
        load_vec = '0;
        drop_vec = '0;
        unique case (action)
            RES_ALLOC:    load_vec[victim_idx] = 1'b1;
            RES_RETARGET: load_vec[rs_idx]     = 1'b1;
            RES_DELETE:   drop_vec[rs_idx]     = 1'b1;
            RES_IDLE, RES_IGNORE: ;
            default: ;
        endcase
    end

    assign alloc_fire = (action == RES_ALLOC);

    // outputs
    always_comb begin
        lk_taken      = lk_hit && pred_vec[lk_idx];
        lk_next_pc    = lk_taken ? tgt_arr[lk_idx] : lk_pc + STEP_V;
        rs_mispredict = rs_valid && rs_was_hit && !rs_taken;
    end

endmodule

// File: rtl/btb_unit_chk.sv
module btb_unit_chk #(
    parameter int N       = 8,
    parameter int PC_W    = 32,
    parameter int PC_STEP = 4,
    parameter int IDX_W   = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PC_W-1:0] lk_pc,
    input logic            lk_hit,
    input logic            lk_taken,
    input logic [PC_W-1:0] lk_next_pc,
    input logic            rs_valid,
    input logic            rs_taken,
    input logic            rs_was_hit,
    input logic [N-1:0]    held_vec,
    input logic [N-1:0]    lk_hit_vec,
    input logic            rs_hit,
    input logic            alloc_fire,
    input logic [IDX_W-1:0] rr_ptr
);

    // R3
    miss_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> lk_next_pc == lk_pc + PC_W'(PC_STEP));

    // R3
    taken_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_taken |-> lk_hit);

    // R2
    unique_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_hit_vec));

    // R4
    alloc_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && rs_taken && !rs_hit && !(&held_vec))
        |=> $countones(held_vec) == $past($countones(held_vec)) + 1);

    // R5
    retarget_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && rs_taken && rs_hit) |=> ($stable(held_vec) && $stable(rr_ptr)));

    // R6
    delete_shrinks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && !rs_taken && rs_was_hit && rs_hit)
        |=> $countones(held_vec) == $past($countones(held_vec)) - 1);

    // R8
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_fire |=> rr_ptr == (($past(rr_ptr) == IDX_W'(N - 1)) ? '0 : $past(rr_ptr) + 1'b1));

    // R10
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rs_valid |=> $stable(held_vec));

endmodule

bind btb_unit btb_unit_chk #(
    .N(NUM_ENTRIES), .PC_W(PC_W), .PC_STEP(PC_STEP), .IDX_W(IDX_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_pc      (lk_pc),
    .lk_hit     (lk_hit),
    .lk_taken   (lk_taken),
    .lk_next_pc (lk_next_pc),
    .rs_valid   (rs_valid),
    .rs_taken   (rs_taken),
    .rs_was_hit (rs_was_hit),
    .held_vec   (held_vec),
    .lk_hit_vec (lk_hit_vec),
    .rs_hit     (rs_hit),
    .alloc_fire (alloc_fire),
    .rr_ptr     (rr_ptr)
);

// File: tb/btb_unit_tb_top.sv
`timescale 1ns/1ps
module btb_unit_tb_top;

    localparam int NE = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_pc = '0;
    logic        lk_hit, lk_taken, rs_mispredict;
    logic [31:0] lk_next_pc;
    logic        rs_valid = 1'b0;
    logic [31:0] rs_pc = '0;
    logic        rs_taken = 1'b0;
    logic [31:0] rs_target = '0;
    logic        rs_was_hit = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference table
    bit          m_v   [NE];
    logic [31:0] m_tag [NE];
    logic [31:0] m_tgt [NE];
    int          m_ptr;

    always #2 clk = ~clk;

    btb_unit dut_i (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_hit(lk_hit),
        .lk_taken(lk_taken), .lk_next_pc(lk_next_pc), .rs_valid(rs_valid),
        .rs_pc(rs_pc), .rs_taken(rs_taken), .rs_target(rs_target),
        .rs_was_hit(rs_was_hit), .rs_mispredict(rs_mispredict)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int m_find(input logic [31:0] pc);
        for (int i = 0; i < NE; i++) if (m_v[i] && m_tag[i] == pc) return i;
        return -1;
    endfunction

    // one cycle: drive, check from pre-update model, clock, update model
    task automatic step(input string req, input logic [31:0] lpc, input logic rv,
                        input logic [31:0] rpc, input logic rt,
                        input logic [31:0] rtg, input logic rh);
        int hi, ri, fe;
        @(negedge clk);
        lk_pc = lpc; rs_valid = rv; rs_pc = rpc; rs_taken = rt;
        rs_target = rtg; rs_was_hit = rh;
        #1;
        hi = m_find(lpc);
        chk(req, "lk_hit", {31'd0, lk_hit}, {31'd0, hi >= 0});
        chk(req, "lk_taken", {31'd0, lk_taken}, {31'd0, hi >= 0});
        chk(req, "lk_next_pc", lk_next_pc, (hi >= 0) ? m_tgt[hi] : lpc + 32'd4);
        chk(req, "rs_mispredict", {31'd0, rs_mispredict}, {31'd0, rv && rh && !rt});
        @(posedge clk);
        ri = m_find(rpc);
        if (rv) begin
            if (rt) begin
                if (ri >= 0) m_tgt[ri] = rtg;
                else begin
                    fe = -1;
                    for (int i = NE - 1; i >= 0; i--) if (!m_v[i]) fe = i;
                    if (fe < 0) fe = m_ptr;
                    m_v[fe] = 1'b1; m_tag[fe] = rpc; m_tgt[fe] = rtg;
                    m_ptr = (m_ptr + 1) % NE;
                end
            end else if (rh && ri >= 0) begin
                m_v[ri] = 1'b0;
            end
        end
    endtask

    task automatic look(input string req, input logic [31:0] pc);
        step(req, pc, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0);
    endtask

    function automatic logic [31:0] bpc(input int i);
        return 32'h0000_1000 + 32'(i) * 32'h10;
    endfunction
    function automatic logic [31:0] btg(input int i);
        return 32'h0000_8000 + 32'(i) * 32'h40;
    endfunction

    initial begin
        logic [15:0] lf;
        for (int i = 0; i < NE; i++) begin m_v[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0; end
        m_ptr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: empty after reset, sequential next PC with wrap
        look("R1", 32'h0);
        look("R1", 32'h0000_1000);
        look("R1", 32'hFFFF_FFFC);

        // R4/R9: fill all slots, same-cycle lookup sees old contents
        for (int i = 0; i < NE; i++)
            step("R4/R9", bpc(i), 1'b1, bpc(i), 1'b1, btg(i), 1'b0);

        // R2/R3: exact full-PC match sweep
        for (int i = 0; i < NE; i++) begin
            look("R3", bpc(i));
            look("R2", bpc(i) + 32'd4);
            look("R2", bpc(i) ^ 32'h8000_0000);
        end

        // R10: resolve without valid leaves table alone
        step("R10", 32'h5000, 1'b0, 32'h5000, 1'b1, 32'h9999_0000, 1'b0);
        look("R10", 32'h5000);

        // R5: retarget in place, pointer not moved
        step("R5", bpc(3), 1'b1, bpc(3), 1'b1, 32'hABCD_0000, 1'b1);
        look("R5", bpc(3));
        // R8: full table, allocation evicts slot at pointer 0
        step("R8", 32'h6000, 1'b1, 32'h6000, 1'b1, 32'h0000_6600, 1'b0);
        look("R8", bpc(0));
        look("R8", bpc(1));
        look("R8", 32'h6000);

        // R6/R9: delete on not-taken hit; lookup in same cycle still hits
        step("R6/R9", bpc(2), 1'b1, bpc(2), 1'b0, 32'h0, 1'b1);
        look("R6", bpc(2));

        // R7: not-taken without hit flag changes nothing
        step("R7", bpc(4), 1'b1, bpc(4), 1'b0, 32'h0, 1'b0);
        look("R7", bpc(4));
        step("R7", 32'h7777, 1'b1, 32'h7777, 1'b0, 32'h0, 1'b1);

        // R4/R8: free slot taken first, then pointer victim
        step("R4", 32'h6100, 1'b1, 32'h6100, 1'b1, 32'h0000_6610, 1'b0);
        look("R4", 32'h6100);
        step("R8", 32'h6200, 1'b1, 32'h6200, 1'b1, 32'h0000_6620, 1'b0);
        look("R8", 32'h6100);
        look("R8", 32'h6200);

        // R3/R9 mix: pseudo-random resolves over a 12-PC pool
        lf = 16'hACE1;
        for (int n = 0; n < 600; n++) begin
            logic [31:0] a, b;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            a = 32'h2000 + 32'(lf[3:0] % 12) * 4;
            b = 32'h2000 + 32'(lf[9:6] % 12) * 4;
            step("R3", a, lf[11] | lf[4], b, lf[12], {16'h0, lf}, lf[14]);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule